// File: doc/BRIEF.md
# I2C Transfer Byte Counter with Reload

This block tracks the length of an I2C transfer in bytes. Software loads an 8-bit byte count together with a handful of control bits through a single-cycle write port. The count then drops by one each time the bit engine reports a finished byte at the acknowledge pulse. The engine's report is the `byte_done` strobe. When the count runs out, the block does one of two things. It may tell the bus controller how to close the transfer: STOP, repeated START, NACK, or NACK followed by STOP. Otherwise it raises a reload flag that holds SCL low until software supplies a fresh count.

Reload mode serves two cases. The first is a transfer longer than 255 bytes, which is split into chunks of at most 255. The second is a receiver that must decide the acknowledge value of individual bytes, since it can stop the clock after every chunk. Software clears the reload bit when it loads the last chunk, and that chunk then ends with the normal completion action.

In controller (master) mode the counter always runs. In target (slave) mode it runs only when the slave byte-control bit is set. In target mode a non-reload count that runs out produces no bus request, because closing the transfer is the controller's job.

Top module: `xfer_len_ctr`

## Requirements
- R1: After reset, `bytes_left` is 0 and `tcr_flag`, `tcr_irq`, `scl_hold`, `req_stop`, `req_restart` and `req_nack` are all 0.
- R2: A cycle with `cfg_we`=1 loads `cfg_count` (0 to 255) into `bytes_left` on the next edge and stores reload, slave control, interrupt enable and end mode. A `byte_done` in the same cycle is not counted.
- R3: An accepted `byte_done` lowers `bytes_left` by exactly one. A `byte_done` while `bytes_left` is 0 leaves it at 0 and produces no request and no flag.
- R4: Counting is enabled when `is_master`=1, or when `is_master`=0 and the stored slave control bit is 1. While counting is disabled, `byte_done` leaves `bytes_left` unchanged.
- R5: With reload stored as 1, the byte that takes `bytes_left` from 1 to 0 sets `tcr_flag` on the same edge. `scl_hold` is 1 exactly while `tcr_flag` is 1.
- R6: `tcr_irq` is 1 exactly when `tcr_flag` is 1 and the stored interrupt enable is 1.
- R7: `tcr_flag` is cleared only by a write with a non-zero `cfg_count`. A write of 0 leaves it set. While it is set, `byte_done` does not change `bytes_left`.
- R8: After a non-zero write clears `tcr_flag`, counting restarts from the written value. If that write clears reload, reaching zero gives the normal completion action of R9.
- R9: With reload 0 and `is_master`=1, the byte that takes `bytes_left` to 0 produces, for exactly the following cycle, requests set by `cfg_end_mode`: 00 sets `req_stop`; 01 sets `req_restart`; 10 sets `req_nack`; 11 sets both `req_nack` and `req_stop`.
- R10: With reload 0 and `is_master`=0 (slave control 1), reaching 0 produces no request and does not set `tcr_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = controller mode, 0 = target mode |
| cfg_we | input | 1 | Write strobe for the control fields below |
| cfg_count | input | 8 | Byte count to load |
| cfg_reload | input | 1 | Reload mode enable |
| cfg_slave_ctl | input | 1 | Enables counting in target mode |
| cfg_irq_en | input | 1 | Interrupt enable for the reload flag |
| cfg_end_mode | input | 2 | Completion action selector (see R9) |
| byte_done | input | 1 | One-cycle strobe at a byte's acknowledge pulse |
| bytes_left | output | 8 | Remaining byte count |
| tcr_flag | output | 1 | Reload-complete flag |
| tcr_irq | output | 1 | Interrupt request for the reload flag |
| scl_hold | output | 1 | Request to hold SCL low |
| req_stop | output | 1 | One-cycle STOP request |
| req_restart | output | 1 | One-cycle repeated-START request |
| req_nack | output | 1 | One-cycle NACK request |

## Verification
A software write of the count and a byte-done strobe can arrive in the same cycle. Both write the same register, so the bench deliberately asserts `cfg_we` and `byte_done` on one clock. It then expects `bytes_left` to show the written value unchanged, with no request or flag from the dropped byte. A second collision is a zero write or a stray strobe while the reload flag holds the clock. The bench judges it by checking that the flag, the hold and the remaining count all survive until a non-zero write arrives.

// File: rtl/xlc_pkg.sv
package xlc_pkg;

    localparam int CNT_W   = 8;
    localparam int NUM_ACT = 3;

    // index of each completion request in the action vector
    localparam int ACT_STOP    = 0;
    localparam int ACT_RESTART = 1;
    localparam int ACT_NACK    = 2;

    typedef enum logic [1:0] {
        END_STOP      = 2'b00,
        END_RESTART   = 2'b01,
        END_NACK      = 2'b10,
        END_NACK_STOP = 2'b11
    } end_mode_e;

    typedef struct packed {
        logic      reload;
        logic      slave_ctl;
        logic      irq_en;
        end_mode_e end_mode;
    } ctl_t;

    function automatic logic act_on(end_mode_e m, int idx);
        logic r;
        r = 1'b0;
        case (idx)
            ACT_STOP:    r = (m == END_STOP) || (m == END_NACK_STOP);
            ACT_RESTART: r = (m == END_RESTART);
            ACT_NACK:    r = (m == END_NACK) || (m == END_NACK_STOP);
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xlc_cfg.sv
module xlc_cfg
    import xlc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      is_master,
    input  logic      wr_en,
    input  ctl_t      wr_ctl,
    output ctl_t      ctl,
    output logic      count_en
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (wr_en) begin
            ctl_d = wr_ctl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{reload: 1'b0, slave_ctl: 1'b0, irq_en: 1'b0, end_mode: END_STOP};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl      = ctl_q;
    assign count_en = is_master | ctl_q.slave_ctl;

endmodule

// File: rtl/xlc_count.sv
module xlc_count
    import xlc_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         count_en,
    input  logic         reload,
    input  logic         wr_en,
    input  logic [W-1:0] wr_count,
    input  logic         byte_done,
    output logic [W-1:0] cnt,
    output logic         tcr,
    output logic         end_evt
);

    localparam logic [W-1:0] ONE  = W'(1);
    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         tcr;
    } st_t;

    st_t  st_d, st_q;
    logic accept;
    logic last;

    always_comb begin
        st_d    = st_q;
        accept  = byte_done && count_en && !st_q.tcr && (st_q.cnt != ZERO) && !wr_en;
        last    = accept && (st_q.cnt == ONE);
        end_evt = last && !reload;
        if (wr_en) begin
            st_d.cnt = wr_count;
            if (wr_count != ZERO) begin
                st_d.tcr = 1'b0;
            end
        end else if (accept) begin
            st_d.cnt = st_q.cnt - ONE;
            if (last && reload) begin
                st_d.tcr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: ZERO, tcr: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign tcr = st_q.tcr;

endmodule

// File: rtl/xlc_end.sv
module xlc_end
    import xlc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               end_evt,
    input  logic               is_master,
    input  end_mode_e          end_mode,
    output logic [NUM_ACT-1:0] req
);

    logic [NUM_ACT-1:0] req_d, req_q;
    logic [NUM_ACT-1:0] sel;

    for (genvar i = 0; i < NUM_ACT; i++) begin : g_sel
        assign sel[i] = act_on(end_mode, i);
    end

    always_comb begin
        req_d = '0;
        if (end_evt && is_master) begin
            req_d = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign req = req_q;

endmodule

// File: rtl/xfer_len_ctr.sv
module xfer_len_ctr
    import xlc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_reload,
    input  logic             cfg_slave_ctl,
    input  logic             cfg_irq_en,
    input  logic [1:0]       cfg_end_mode,
    input  logic             byte_done,
    output logic [CNT_W-1:0] bytes_left,
    output logic             tcr_flag,
    output logic             tcr_irq,
    output logic             scl_hold,
    output logic             req_stop,
    output logic             req_restart,
    output logic             req_nack
);

    ctl_t               wr_ctl;
    ctl_t               ctl;
    logic               count_en;
    logic               end_evt;
    logic               tcr;
    logic [NUM_ACT-1:0] req;

    always_comb begin
        wr_ctl.reload    = cfg_reload;
        wr_ctl.slave_ctl = cfg_slave_ctl;
        wr_ctl.irq_en    = cfg_irq_en;
        wr_ctl.end_mode  = end_mode_e'(cfg_end_mode);
    end

    xlc_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .is_master(is_master),
        .wr_en    (cfg_we),
        .wr_ctl   (wr_ctl),
        .ctl      (ctl),
        .count_en (count_en)
    );

    xlc_count #(.W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .reload   (ctl.reload),
        .wr_en    (cfg_we),
        .wr_count (cfg_count),
        .byte_done(byte_done),
        .cnt      (bytes_left),
        .tcr      (tcr),
        .end_evt  (end_evt)
    );

    xlc_end u_end (
        .clk      (clk),
        .rst_n    (rst_n),
        .end_evt  (end_evt),
        .is_master(is_master),
        .end_mode (ctl.end_mode),
        .req      (req)
    );

    assign tcr_flag    = tcr;
    assign scl_hold    = tcr;
    assign tcr_irq     = tcr & ctl.irq_en;
    assign req_stop    = req[ACT_STOP];
    assign req_restart = req[ACT_RESTART];
    assign req_nack    = req[ACT_NACK];

endmodule

// File: rtl/xlc_checker.sv
module xlc_checker
    import xlc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             is_master,
    input logic             cfg_we,
    input logic [CNT_W-1:0] cfg_count,
    input logic             byte_done,
    input logic [CNT_W-1:0] bytes_left,
    input logic             tcr_flag,
    input logic             scl_hold,
    input logic             req_stop,
    input logic             req_restart,
    input logic             req_nack
);

    // R2: a write lands its count on the next edge
    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> bytes_left == $past(cfg_count));

    // R3: controller-mode byte while counting lowers count by one
    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && byte_done && !cfg_we && !tcr_flag && bytes_left != '0)
        |=> bytes_left == CNT_W'($past(bytes_left) - CNT_W'(1)));

    // R3: nothing counts below zero
    assert_zero_stays_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bytes_left == '0 && !cfg_we) |=> bytes_left == '0);

    // R5: the flag only appears after the last byte of a chunk
    assert_tcr_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tcr_flag) |-> ($past(bytes_left) == CNT_W'(1) && $past(byte_done) && bytes_left == '0));

    // R5: clock is held whenever the flag is up
    assert_hold_with_tcr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tcr_flag |-> scl_hold);

    // R7: flag persists until a non-zero write
    assert_tcr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tcr_flag && !(cfg_we && cfg_count != '0)) |=> tcr_flag);

    // R7: count frozen while the flag is up and no write happens
    assert_tcr_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tcr_flag && !cfg_we) |=> $stable(bytes_left));

    // R9: requests only at count zero with no flag, restart exclusive
    assert_req_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_stop || req_restart || req_nack) |-> (!tcr_flag && $past(bytes_left) == CNT_W'(1)));

    assert_restart_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_restart |-> !(req_stop || req_nack));

endmodule

bind xfer_len_ctr xlc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_master  (is_master),
    .cfg_we     (cfg_we),
    .cfg_count  (cfg_count),
    .byte_done  (byte_done),
    .bytes_left (bytes_left),
    .tcr_flag   (tcr_flag),
    .scl_hold   (scl_hold),
    .req_stop   (req_stop),
    .req_restart(req_restart),
    .req_nack   (req_nack)
);

// File: tb/xfer_len_ctr_bench.sv
`timescale 1ns/1ps
module xfer_len_ctr_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_count = '0;
    logic       cfg_reload = 1'b0;
    logic       cfg_slave_ctl = 1'b0;
    logic       cfg_irq_en = 1'b0;
    logic [1:0] cfg_end_mode = '0;
    logic       byte_done = 1'b0;
    logic [7:0] bytes_left;
    logic       tcr_flag, tcr_irq, scl_hold, req_stop, req_restart, req_nack;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    xfer_len_ctr u_xfer_len_ctr (.*);

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(int cnt, bit rl, bit sc, bit ie, int em);
        @(negedge clk);
        cfg_we = 1'b1; cfg_count = 8'(cnt); cfg_reload = rl;
        cfg_slave_ctl = sc; cfg_irq_en = ie; cfg_end_mode = 2'(em);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // strobe one byte; returns sampled one cycle after the strobe edge
    task automatic one_byte();
        @(negedge clk);
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
    endtask

    task automatic check_reqs(string req, bit s, bit r, bit n);
        check(req, {req_stop, req_restart, req_nack}, {s, r, n});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int lens [5] = '{1, 2, 3, 7, 255};
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 count", bytes_left, 0);
        check("R1 tcr", {tcr_flag, tcr_irq, scl_hold}, 0);
        check_reqs("R1 reqs", 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 strobe at zero
        one_byte();
        check("R3 zero count", bytes_left, 0);
        check_reqs("R3 zero reqs", 0, 0, 0);

        // sweep: end mode x reload x length, controller mode
        for (int em = 0; em < 4; em++) begin
            for (int rl = 0; rl < 2; rl++) begin
                foreach (lens[k]) begin
                    int n;
                    bit ie;
                    n  = lens[k];
                    ie = em[0];
                    write_cfg(n, rl[0], 1'b0, ie, em);
                    check("R2 load", bytes_left, n);
                    for (int b = 1; b <= n; b++) begin
                        one_byte();
                        check("R3 dec", bytes_left, n - b);
                        if (b < n) begin
                            check("R5 no tcr early", tcr_flag, 0);
                            check_reqs("R9 no req early", 0, 0, 0);
                        end
                    end
                    if (rl == 1) begin
                        check("R5 tcr", tcr_flag, 1);
                        check("R5 hold", scl_hold, 1);
                        check("R6 irq", tcr_irq, int'(ie));
                        check_reqs("R9 none in reload", 0, 0, 0);
                        write_cfg(1, 1'b0, 1'b0, 1'b0, 0);
                        check("R7 clear", tcr_flag, 0);
                        one_byte();
                        check_reqs("R8 final chunk", 1, 0, 0);
                    end else begin
                        check("R9 no tcr", tcr_flag, 0);
                        check_reqs("R9 req", (em == 0 || em == 3), (em == 1), (em >= 2));
                        @(negedge clk);
                        check_reqs("R9 one cycle", 0, 0, 0);
                    end
                end
            end
        end

        // R7: zero write and stray strobe while flag is up
        write_cfg(2, 1'b1, 1'b0, 1'b1, 0);
        one_byte(); one_byte();
        check("R5 tcr chain", tcr_flag, 1);
        write_cfg(0, 1'b1, 1'b0, 1'b1, 0);
        check("R7 zero write keeps tcr", tcr_flag, 1);
        check("R7 hold kept", scl_hold, 1);
        write_cfg(9, 1'b1, 1'b0, 1'b1, 0);
        check("R7 nonzero clears", tcr_flag, 0);
        write_cfg(2, 1'b1, 1'b0, 1'b0, 0);
        one_byte(); one_byte();
        one_byte();
        check("R7 strobe ignored count", bytes_left, 0);
        check("R7 strobe ignored tcr", tcr_flag, 1);
        check("R6 irq off", tcr_irq, 0);
        // R8 restart from new value with reload cleared
        write_cfg(3, 1'b0, 1'b0, 1'b0, 1);
        check("R8 tcr cleared", tcr_flag, 0);
        one_byte();
        check("R8 restart value", bytes_left, 2);
        one_byte(); one_byte();
        check_reqs("R8 completion", 0, 1, 0);

        // R2 collision: write and strobe in one cycle
        write_cfg(5, 1'b0, 1'b0, 1'b0, 0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_count = 8'd4; byte_done = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; byte_done = 1'b0;
        check("R2 collision count", bytes_left, 4);
        check_reqs("R2 collision reqs", 0, 0, 0);
        write_cfg(1, 1'b0, 1'b0, 1'b0, 0);
        @(negedge clk);
        cfg_we = 1'b1; cfg_count = 8'd1; byte_done = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; byte_done = 1'b0;
        check("R2 collision last", bytes_left, 1);
        check_reqs("R2 collision no end", 0, 0, 0);

        // R4 target mode without slave control
        is_master = 1'b0;
        write_cfg(4, 1'b0, 1'b0, 1'b0, 0);
        one_byte(); one_byte();
        check("R4 disabled", bytes_left, 4);
        // R10 target mode with slave control, no reload
        write_cfg(2, 1'b0, 1'b1, 1'b0, 0);
        one_byte();
        check("R4 enabled", bytes_left, 1);
        one_byte();
        check("R10 count", bytes_left, 0);
        check_reqs("R10 no req", 0, 0, 0);
        check("R10 no tcr", tcr_flag, 0);
        // target with reload
        write_cfg(1, 1'b1, 1'b1, 1'b1, 0);
        one_byte();
        check("R5 target tcr", tcr_flag, 1);
        check("R6 target irq", tcr_irq, 1);
        write_cfg(3, 1'b0, 1'b1, 1'b1, 0);
        check("R6 irq drops", tcr_irq, 0);
        is_master = 1'b1;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule